// File: doc/BRIEF.md
# Dual-Channel Converter Command Executor

This block sits behind a serial front end that has already collected a
command nibble, an address nibble and a 16-bit data word. When the execute
strobe pulses for one clock, the block applies that triple to its state. Each
of two channels holds a staging register and a live register. The live
register is the code that the converter would output. The block also holds a
power-down flag per channel, which reference source is selected, and whether
the on-chip reference is powered. A busy flag models the time the outputs
need to settle after a channel wakes from power-down.

The code resolution is a parameter and may be 8, 10 or 12 bits. The code is
taken left-aligned from the data word. Parameters also set the reset values:
zero-scale or mid-scale codes, and internal or external reference. When the
external reference is chosen, mid-scale codes are always used. A
ticks-per-microsecond parameter scales the settling counter.

Top module: `dac_cmd_exec`

## Requirements
- R1: After reset both live codes are zero, or mid-scale (only the MSB set) when mid-scale reset or external-reference reset is chosen. Both channels are powered, busy is low, and the reference is internal and powered unless external-reference reset is chosen, in which case it is external and unpowered.
- R2: Command 4'h0 loads the staging register of the addressed channel and leaves the live codes unchanged.
- R3: Command 4'h1 copies the staging register of the addressed channel into its live register and clears its power-down flag.
- R4: Command 4'h2 loads the staging register of the addressed channel. It then copies both staging registers to their live registers and powers up both channels.
- R5: Command 4'h3 loads the data into both the staging and live registers of the addressed channel and powers that channel up.
- R6: Address 4'h0 selects channel A (power-down bit 0) and 4'h1 selects channel B (bit 1). Address 4'hF selects both channels, and a write then loads the same code into both. Any other address makes commands 4'h0 to 4'h4 change nothing.
- R7: Command 4'hF and every unlisted command change no state. Without the strobe, no state changes.
- R8: The code is data bits [15:16-RES_BITS]. The lower data bits are ignored, and commands without a write ignore the whole data word.
- R9: Command 4'h4 sets the power-down flag of the addressed channel and keeps its staging and live contents.
- R10: Command 4'h5 powers down both channels and the reference. After that, a later command that updates a live register powers the reference up again.
- R11: Command 4'h7 selects the external reference and powers the internal one down. Only command 4'h6 then selects and powers the internal reference again; updates do not.
- R12: An update that wakes a powered-down channel holds busy high for exactly 10*TICKS_PER_US cycles, starting the cycle after the strobe. An update that wakes nothing, and a power-down, leave busy low.
- R13: If both channels were down and the reference had been shut down by command 4'h5, the wake-up holds busy for 12*TICKS_PER_US cycles instead.
- R14: Commands still take effect while busy is high. A new wake-up restarts the full settling count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | One-cycle strobe that applies the fields |
| cmd_i | input | 4 | Command nibble |
| addr_i | input | 4 | Channel address nibble |
| data_i | input | 16 | Data word, code left-aligned |
| code_a_o | output | RES_BITS | Live code of channel A |
| code_b_o | output | RES_BITS | Live code of channel B |
| pd_o | output | 2 | Power-down flags, bit 0 = A, bit 1 = B |
| ref_int_o | output | 1 | High when the internal reference is selected |
| ref_on_o | output | 1 | High when the internal reference is powered |
| busy_o | output | 1 | High while outputs settle after a wake-up |

## Verification
On every cycle the assertions check the following properties. Idle cycles,
reserved commands and reserved addresses leave every output unchanged.
Channel and chip power-down set the expected flags. External-reference
selection turns the reference off and keeps it off until command 4'h6. A
write-and-update lands the left-aligned code. Waking a channel raises busy.
Other behaviour needs the bench's scenarios to show it: the exact 10 µs and
12 µs settling lengths, restarting the count while busy, keeping register
contents across a power-down, and how the reference recovers after each of
the two kinds of shutdown.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    typedef enum logic [3:0] {
        OP_WR_IN      = 4'h0,
        OP_UPD        = 4'h1,
        OP_WR_UPD_ALL = 4'h2,
        OP_WR_UPD     = 4'h3,
        OP_PD_CH      = 4'h4,
        OP_PD_CHIP    = 4'h5,
        OP_REF_INT    = 4'h6,
        OP_REF_EXT    = 4'h7,
        OP_NOP        = 4'hF
    } op_e;

    localparam logic [3:0] ADDR_CH_A = 4'h0;
    localparam logic [3:0] ADDR_CH_B = 4'h1;
    localparam logic [3:0] ADDR_BOTH = 4'hF;
    localparam int         NUM_CH    = 2;

    // One decoded action per strobe; all-zero means "do nothing".
    typedef struct packed {
        logic [NUM_CH-1:0] wr_sel;
        logic [NUM_CH-1:0] upd_sel;
        logic [NUM_CH-1:0] pd_sel;
        logic              ref_int_on;
        logic              ref_ext;
        logic              chip_down;
    } act_t;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_cmd_pkg::*;
(
    input  logic        exec_i,
    input  logic [3:0]  cmd_i,
    input  logic [3:0]  addr_i,
    output act_t        act_o
);

    logic [NUM_CH-1:0] mask;

    always_comb begin
        unique case (addr_i)
            ADDR_CH_A: mask = 2'b01;
            ADDR_CH_B: mask = 2'b10;
            ADDR_BOTH: mask = 2'b11;
            default:   mask = 2'b00;
        endcase
    end

    always_comb begin
        act_o = '0;
        if (exec_i) begin
            case (cmd_i)
                OP_WR_IN: act_o.wr_sel = mask;
                OP_UPD:   act_o.upd_sel = mask;
                OP_WR_UPD_ALL: begin
                    act_o.wr_sel  = mask;
                    act_o.upd_sel = (mask != '0) ? '1 : '0;
                end
                OP_WR_UPD: begin
                    act_o.wr_sel  = mask;
                    act_o.upd_sel = mask;
                end
                OP_PD_CH:   act_o.pd_sel     = mask;
                OP_PD_CHIP: act_o.chip_down  = 1'b1;
                OP_REF_INT: act_o.ref_int_on = 1'b1;
                OP_REF_EXT: act_o.ref_ext    = 1'b1;
                default:    act_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
    parameter int              RES_BITS = 12,
    parameter logic [RES_BITS-1:0] RST_CODE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic                upd_i,
    input  logic                pd_set_i,
    input  logic [RES_BITS-1:0] code_i,
    output logic [RES_BITS-1:0] live_o,
    output logic                pd_o
);

    typedef struct packed {
        logic [RES_BITS-1:0] stage;
        logic [RES_BITS-1:0] live;
        logic                pd;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.stage = code_i;
        end
        if (upd_i) begin
            st_d.live = wr_i ? code_i : st_q.stage;
            st_d.pd   = 1'b0;
        end
        if (pd_set_i) begin
            st_d.pd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage <= RST_CODE;
            st_q.live  <= RST_CODE;
            st_q.pd    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_o = st_q.live;
    assign pd_o   = st_q.pd;

endmodule

// File: rtl/dac_ref_ctrl.sv
module dac_ref_ctrl #(
    parameter bit RST_EXT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_int_i,
    input  logic sel_ext_i,
    input  logic chip_down_i,
    input  logic any_upd_i,
    output logic ref_int_o,
    output logic ref_on_o,
    output logic chip_off_o
);

    typedef struct packed {
        logic int_sel;
        logic on;
        logic chip_off;
    } ref_t;

    ref_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_ext_i) begin
            st_d.int_sel  = 1'b0;
            st_d.on       = 1'b0;
            st_d.chip_off = 1'b0;
        end else if (sel_int_i) begin
            st_d.int_sel  = 1'b1;
            st_d.on       = 1'b1;
            st_d.chip_off = 1'b0;
        end else if (chip_down_i) begin
            st_d.on = 1'b0;
            // only a reference that was running is marked as woken by updates
            st_d.chip_off = st_q.on | st_q.chip_off;
        end else if (any_upd_i && st_q.chip_off) begin
            st_d.on       = 1'b1;
            st_d.chip_off = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.int_sel  <= ~RST_EXT;
            st_q.on       <= ~RST_EXT;
            st_q.chip_off <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_int_o  = st_q.int_sel;
    assign ref_on_o   = st_q.on;
    assign chip_off_o = st_q.chip_off;

endmodule

// File: rtl/dac_settle_timer.sv
module dac_settle_timer #(
    parameter int SHORT_TICKS = 2500,
    parameter int LONG_TICKS  = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic long_i,
    output logic busy_o
);

    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_TICKS);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = long_i ? LONG_LD : SHORT_LD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/dac_cmd_exec.sv
module dac_cmd_exec
    import dac_cmd_pkg::*;
#(
    parameter int RES_BITS       = 12,
    parameter bit RESET_MIDSCALE = 1'b1,
    parameter bit RESET_EXTREF   = 1'b0,
    parameter int TICKS_PER_US   = 250,
    parameter int SETTLE_US      = 10,
    parameter int SETTLE_CHIP_US = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exec_i,
    input  logic [3:0]          cmd_i,
    input  logic [3:0]          addr_i,
    input  logic [15:0]         data_i,
    output logic [RES_BITS-1:0] code_a_o,
    output logic [RES_BITS-1:0] code_b_o,
    output logic [1:0]          pd_o,
    output logic                ref_int_o,
    output logic                ref_on_o,
    output logic                busy_o
);

    // External reference at reset always pairs with mid-scale codes.
    localparam bit                  USE_MID  = RESET_MIDSCALE | RESET_EXTREF;
    localparam logic [RES_BITS-1:0] RST_CODE = USE_MID ? (RES_BITS'(1) << (RES_BITS - 1)) : '0;
    localparam int                  SHORT_T  = SETTLE_US * TICKS_PER_US;
    localparam int                  LONG_T   = SETTLE_CHIP_US * TICKS_PER_US;

    act_t                act;
    logic [RES_BITS-1:0] code_in;
    logic [RES_BITS-1:0] live [NUM_CH];
    logic [NUM_CH-1:0]   pd_vec;
    logic                chip_off;
    logic                wake;
    logic                wake_long;

    assign code_in = data_i[15 -: RES_BITS];

    dac_cmd_decode u_dec (
        .exec_i (exec_i),
        .cmd_i  (cmd_i),
        .addr_i (addr_i),
        .act_o  (act)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dac_chan_regs #(
            .RES_BITS (RES_BITS),
            .RST_CODE (RST_CODE)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (act.wr_sel[ch]),
            .upd_i    (act.upd_sel[ch]),
            .pd_set_i (act.pd_sel[ch] | act.chip_down),
            .code_i   (code_in),
            .live_o   (live[ch]),
            .pd_o     (pd_vec[ch])
        );
    end

    dac_ref_ctrl #(
        .RST_EXT (RESET_EXTREF)
    ) u_ref (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_int_i   (act.ref_int_on),
        .sel_ext_i   (act.ref_ext),
        .chip_down_i (act.chip_down),
        .any_upd_i   (|act.upd_sel),
        .ref_int_o   (ref_int_o),
        .ref_on_o    (ref_on_o),
        .chip_off_o  (chip_off)
    );

    // a wake-up is an update that touches at least one sleeping channel
    assign wake      = |(act.upd_sel & pd_vec);
    assign wake_long = chip_off & (&pd_vec);

    dac_settle_timer #(
        .SHORT_TICKS (SHORT_T),
        .LONG_TICKS  (LONG_T)
    ) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wake),
        .long_i  (wake_long),
        .busy_o  (busy_o)
    );

    assign code_a_o = live[0];
    assign code_b_o = live[1];
    assign pd_o     = pd_vec;

endmodule

// File: rtl/dac_cmd_exec_chk.sv
module dac_cmd_exec_chk #(
    parameter int RES_BITS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                exec_i,
    input logic [3:0]          cmd_i,
    input logic [3:0]          addr_i,
    input logic [15:0]         data_i,
    input logic [RES_BITS-1:0] code_a_o,
    input logic [RES_BITS-1:0] code_b_o,
    input logic [1:0]          pd_o,
    input logic                ref_int_o,
    input logic                ref_on_o,
    input logic                busy_o
);

    logic cmd_known;
    logic addr_used;
    logic addr_ok;

    assign cmd_known = (cmd_i <= 4'h7) || (cmd_i == 4'hF);
    assign addr_used = (cmd_i <= 4'h4);
    assign addr_ok   = (addr_i == 4'h0) || (addr_i == 4'h1) || (addr_i == 4'hF);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(code_a_o) && $stable(code_b_o) && $stable(pd_o)
                    && $stable(ref_int_o) && $stable(ref_on_o)); // R7

    AST_RSVD_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (!cmd_known || cmd_i == 4'hF)) |=> $stable(code_a_o) && $stable(code_b_o)
                    && $stable(pd_o) && $stable(ref_int_o) && $stable(ref_on_o)); // R7

    AST_RSVD_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && addr_used && !addr_ok) |=> $stable(code_a_o) && $stable(code_b_o)
                    && $stable(pd_o) && !$rose(busy_o)); // R6

    AST_PD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == 4'h4 && addr_i == 4'hF) |=> pd_o == 2'b11); // R9

    AST_CHIP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == 4'h5) |=> pd_o == 2'b11 && !ref_on_o); // R10

    AST_EXT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == 4'h7) |=> !ref_int_o && !ref_on_o); // R11

    AST_EXT_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_int_o && !(exec_i && cmd_i == 4'h6)) |=> !ref_on_o); // R11

    AST_WR_UPD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == 4'h3 && addr_i == 4'h0)
            |=> code_a_o == $past(data_i[15 -: RES_BITS]) && !pd_o[0]); // R5

    AST_WAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && cmd_i == 4'h1 && addr_i == 4'h0 && pd_o[0]) |=> busy_o); // R12

endmodule

bind dac_cmd_exec dac_cmd_exec_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec_i),
    .cmd_i     (cmd_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .code_a_o  (code_a_o),
    .code_b_o  (code_b_o),
    .pd_o      (pd_o),
    .ref_int_o (ref_int_o),
    .ref_on_o  (ref_on_o),
    .busy_o    (busy_o)
);

// File: tb/tb_dac_cmd_exec.sv
`timescale 1ns/1ps
module tb_dac_cmd_exec;

    localparam int TPU    = 4;
    localparam int T_SHORT = 10 * TPU;
    localparam int T_LONG  = 12 * TPU;
    localparam int NV     = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [3:0]  cmd_i = 4'h0;
    logic [3:0]  addr_i = 4'h0;
    logic [15:0] data_i = 16'h0;

    logic [11:0] code_a, code_b;
    logic [1:0]  pd;
    logic        ref_int, ref_on, busy;

    logic [7:0]  z8_a, z8_b;
    logic [1:0]  z8_pd;
    logic        z8_int, z8_on, z8_busy;
    logic [9:0]  x10_a, x10_b;
    logic [1:0]  x10_pd;
    logic        x10_int, x10_on, x10_busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dac_cmd_exec #(.RES_BITS(12), .RESET_MIDSCALE(1'b1), .RESET_EXTREF(1'b0), .TICKS_PER_US(TPU)) dut (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .cmd_i(cmd_i), .addr_i(addr_i), .data_i(data_i),
        .code_a_o(code_a), .code_b_o(code_b), .pd_o(pd), .ref_int_o(ref_int), .ref_on_o(ref_on),
        .busy_o(busy));

    dac_cmd_exec #(.RES_BITS(8), .RESET_MIDSCALE(1'b0), .RESET_EXTREF(1'b0), .TICKS_PER_US(TPU)) dut_z8 (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .cmd_i(cmd_i), .addr_i(addr_i), .data_i(data_i),
        .code_a_o(z8_a), .code_b_o(z8_b), .pd_o(z8_pd), .ref_int_o(z8_int), .ref_on_o(z8_on),
        .busy_o(z8_busy));

    dac_cmd_exec #(.RES_BITS(10), .RESET_MIDSCALE(1'b0), .RESET_EXTREF(1'b1), .TICKS_PER_US(TPU)) dut_x10 (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .cmd_i(cmd_i), .addr_i(addr_i), .data_i(data_i),
        .code_a_o(x10_a), .code_b_o(x10_b), .pd_o(x10_pd), .ref_int_o(x10_int), .ref_on_o(x10_on),
        .busy_o(x10_busy));

    // {cmd, addr, data, exp_a, exp_b, exp_pd, exp_int, exp_on}
    localparam logic [51:0] VEC [NV] = '{
        {4'h0, 4'h0, 16'h1234, 12'h800, 12'h800, 2'b00, 1'b1, 1'b1}, // R2
        {4'h1, 4'h0, 16'hFFFF, 12'h123, 12'h800, 2'b00, 1'b1, 1'b1}, // R3 R8
        {4'h3, 4'h1, 16'hABCF, 12'h123, 12'hABC, 2'b00, 1'b1, 1'b1}, // R5 R8
        {4'h0, 4'hF, 16'h5550, 12'h123, 12'hABC, 2'b00, 1'b1, 1'b1}, // R6
        {4'h1, 4'hF, 16'h0000, 12'h555, 12'h555, 2'b00, 1'b1, 1'b1}, // R6
        {4'h0, 4'h2, 16'h9990, 12'h555, 12'h555, 2'b00, 1'b1, 1'b1}, // R6
        {4'h1, 4'hF, 16'h0000, 12'h555, 12'h555, 2'b00, 1'b1, 1'b1}, // R6
        {4'h8, 4'h0, 16'h7770, 12'h555, 12'h555, 2'b00, 1'b1, 1'b1}, // R7
        {4'h1, 4'h0, 16'h0000, 12'h555, 12'h555, 2'b00, 1'b1, 1'b1}, // R7
        {4'hF, 4'h0, 16'h1110, 12'h555, 12'h555, 2'b00, 1'b1, 1'b1}, // R7
        {4'h4, 4'h0, 16'h0000, 12'h555, 12'h555, 2'b01, 1'b1, 1'b1}, // R9
        {4'h0, 4'h0, 16'h2220, 12'h555, 12'h555, 2'b01, 1'b1, 1'b1}, // R9
        {4'h1, 4'h0, 16'h0000, 12'h222, 12'h555, 2'b00, 1'b1, 1'b1}, // R9 R3
        {4'h4, 4'hF, 16'h0000, 12'h222, 12'h555, 2'b11, 1'b1, 1'b1}, // R9
        {4'h2, 4'h1, 16'h3330, 12'h222, 12'h333, 2'b00, 1'b1, 1'b1}, // R4
        {4'h5, 4'h0, 16'h0000, 12'h222, 12'h333, 2'b11, 1'b1, 1'b0}, // R10
        {4'h1, 4'h0, 16'h0000, 12'h222, 12'h333, 2'b10, 1'b1, 1'b1}, // R10
        {4'h7, 4'h0, 16'h0000, 12'h222, 12'h333, 2'b10, 1'b0, 1'b0}, // R11
        {4'h3, 4'h1, 16'h4440, 12'h222, 12'h444, 2'b00, 1'b0, 1'b0}, // R11
        {4'h5, 4'h0, 16'h0000, 12'h222, 12'h444, 2'b11, 1'b0, 1'b0}, // R11
        {4'h1, 4'hF, 16'h0000, 12'h222, 12'h444, 2'b00, 1'b0, 1'b0}, // R11
        {4'h6, 4'h0, 16'hBEEF, 12'h222, 12'h444, 2'b00, 1'b1, 1'b1}  // R11
    };

    function automatic string vec_req(input int i);
        case (i)
            0: return "R2";
            1: return "R3/R8";
            2: return "R5/R8";
            3, 4, 5, 6: return "R6";
            7, 8, 9: return "R7";
            10, 11, 12, 13: return "R9";
            14: return "R4";
            15, 16: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_i  = c;
        addr_i = a;
        data_i = d;
        exec_i = 1'b1;
        @(negedge clk);
        exec_i = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 5000) begin
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n;
        logic [51:0] v;
        logic [47:0] got;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state of the mid-scale, internal-reference instance
        check(code_a == 12'h800 && code_b == 12'h800, "R1", "reset codes",
              {code_a, code_b}, {12'h800, 12'h800});
        check(pd == 2'b00 && ref_int && ref_on && !busy, "R1", "reset flags",
              {pd, ref_int, ref_on, busy}, {2'b00, 1'b1, 1'b1, 1'b0});

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            issue(v[51:48], v[47:44], v[43:28]);
            got = {code_a, code_b, pd, ref_int, ref_on, 20'h0};
            check({code_a, code_b, pd, ref_int, ref_on} == v[27:0], vec_req(i),
                  $sformatf("vector %0d", i), {36'h0, code_a, code_b, pd, ref_int, ref_on},
                  {36'h0, v[27:0]});
        end

        wait_idle();

        // R12 power-down alone does not start settling
        issue(4'h4, 4'h0, 16'h0);
        check(!busy, "R12", "busy after power-down", busy, 0);
        issue(4'h1, 4'h0, 16'h0);
        count_busy(n);
        check(n == T_SHORT, "R12", "short settle length", n, T_SHORT);
        issue(4'h1, 4'h0, 16'h0);
        check(!busy, "R12", "update of awake channel", busy, 0);

        // R13 wake from full chip shutdown
        issue(4'h5, 4'h0, 16'h0);
        issue(4'h1, 4'h0, 16'h0);
        check(ref_on && pd == 2'b10, "R13", "reference back on", {pd, ref_on}, {2'b10, 1'b1});
        count_busy(n);
        check(n == T_LONG, "R13", "long settle length", n, T_LONG);

        // R14 commands accepted while busy, and a new wake restarts the count
        issue(4'h4, 4'h0, 16'h0);
        issue(4'h1, 4'hF, 16'h0);
        repeat (10) @(negedge clk);
        issue(4'h4, 4'h0, 16'h0);
        check(busy && pd == 2'b01, "R14", "power-down while busy", {busy, pd}, {1'b1, 2'b01});
        issue(4'h3, 4'h0, 16'h6660);
        check(code_a == 12'h666, "R14", "write while busy", code_a, 12'h666);
        count_busy(n);
        check(n == T_SHORT, "R14", "restarted settle length", n, T_SHORT);

        // R1 R8 other resolutions and reset options
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(z8_a == 8'h00 && z8_b == 8'h00 && z8_int && z8_on, "R1", "zero-scale reset",
              {z8_a, z8_b, z8_int, z8_on}, {8'h00, 8'h00, 1'b1, 1'b1});
        check(x10_a == 10'h200 && x10_b == 10'h200 && !x10_int && !x10_on, "R1",
              "external-reference reset", {x10_a, x10_b, x10_int, x10_on},
              {10'h200, 10'h200, 1'b0, 1'b0});
        issue(4'h3, 4'h1, 16'hA5C0);
        check(code_b == 12'hA5C, "R8", "12-bit code", code_b, 12'hA5C);
        check(z8_b == 8'hA5, "R8", "8-bit code", z8_b, 8'hA5);
        check(x10_b == 10'h297, "R8", "10-bit code", x10_b, 10'h297);
        check(!x10_on, "R11", "update leaves external mode off", x10_on, 0);

        finish_run();
    end

endmodule